// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block keeps a DDR SDRAM refreshed without the memory controller having to count time itself. A free-running interval timer marks each point at which one more auto-refresh becomes due. The block keeps a saturating count of the refreshes that are owed and raises a request towards the controller's arbiter. The request is optional while the bus is quiet and becomes urgent once the backlog is full. When the arbiter grants the bus, the block closes any open rows with a precharge-all if needed. It waits out the row-precharge time, sends the auto-refresh, and then blocks every other command for the refresh cycle time.

The same handshake carries self-refresh. On an entry request and a grant, the block closes the banks if needed, issues the self-refresh command, and drops the clock enable in the same cycle. Refresh counting is frozen while the memory refreshes itself. On an exit request it raises the clock enable again. All commands stay blocked until an activate would be legal, and a separate read-ready flag stays low for the longer wait that reads need after the exit. All nanosecond limits are turned into clock counts at elaboration time, rounding up.

Top module: `dram_refresh_sched`

## Requirements
- R1: The owed-refresh count rises by one every `INTERVAL_CYC` clock cycles after reset and never goes above `MAX_OWED` (8); when the timer expires at the full count the count stays at `MAX_OWED`.
- R2: `ref_urgent` is high exactly when the owed count equals `MAX_OWED`. In the idle state `ref_req` is high when the count is full, or when the count is nonzero and `bus_idle` is high. It is also high when `sr_enter_req` is high, and it is low otherwise.
- R3: A grant while `ref_req` is high and no bank is open gives `cmd` = 2 (auto-refresh) in the next cycle, and the owed count drops by one one cycle after that.
- R4: A grant while any bit of `banks_open` is set gives `cmd` = 1 (precharge-all) in the next cycle, and the following command comes exactly `TRP_CYC` cycles after the precharge-all.
- R5: From the auto-refresh cycle on, `cmd_block` stays high and `cmd` stays 0 (no operation) for `TRFC_CYC` cycles in all; the block is idle again `TRFC_CYC` cycles after the auto-refresh.
- R6: A grant while `sr_enter_req` is high (and the count is not full) gives `cmd` = 3 (self-refresh entry) with `cke` low in that same cycle; if a bank was open, a precharge-all comes `TRP_CYC` cycles earlier. The owed count reads 0 after entry.
- R7: While in self-refresh, `cke` stays low, `cmd` stays 0, `cmd_block` stays high, and the interval timer does not advance.
- R8: `cke` rises in the cycle after `sr_exit_req` is seen in self-refresh. `cmd_block` stays high for `TXSA_CYC` cycles counted from that rise, and `read_ok` stays low for `TXSRD_CYC` cycles counted from it. The interval timer restarts from zero at the rise.
- R9: After reset, `cmd` = 0, `cke` = 1, `ref_req` = 0, `ref_urgent` = 0, `cmd_block` = 0, `read_ok` = 1 and the owed count is 0.
- R10: `TRP_CYC`, `TRFC_CYC` and `TXSA_CYC` equal their limits in nanoseconds divided by the clock period, rounded up to the next whole cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| banks_open | input | NUM_BANKS | One bit per bank, set while that bank holds an open row |
| bus_idle | input | 1 | High when no read or write traffic is waiting |
| grant | input | 1 | Arbiter hands the command bus to this block |
| sr_enter_req | input | 1 | Request to put the memory into self-refresh |
| sr_exit_req | input | 1 | Request to bring the memory out of self-refresh |
| ref_req | output | 1 | Bus request towards the arbiter |
| ref_urgent | output | 1 | Backlog of owed refreshes is full |
| cmd | output | 3 | Command to drive: 0 none, 1 precharge-all, 2 auto-refresh, 3 self-refresh entry |
| cke | output | 1 | Clock enable to the memory |
| cmd_block | output | 1 | No other command may be issued this cycle |
| read_ok | output | 1 | Reads are legal again after a self-refresh exit |
| owed_count | output | OWED_W | Number of refreshes currently owed |

## Verification
The bench builds the block with a 4 ns clock, an interval of 40 cycles and the default backlog of eight. These values give a row-precharge wait of 5 cycles, a refresh cycle time and activate-after-exit wait of 19 cycles (75 ns rounds up), and a read wait of 200 cycles. With an interval this short, every backlog level from empty through saturation is reached within a few hundred cycles. Every cycle of several full refresh periods is compared against an expected command computed from the interval, so the bench checks the exact placement of each precharge, refresh and hold window, both with banks closed and with banks open. The self-refresh cases run the whole 200-cycle read wait, check both of its edges, and check that the timer restarts from zero.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PREA = 3'd1,
        CMD_AREF = 3'd2,
        CMD_SRE  = 3'd3
    } ref_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREA,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RFC,
        ST_SRE,
        ST_SELF,
        ST_XS_WAIT
    } ref_state_e;

    // control from the sequencer to the owed-refresh counter
    typedef struct packed {
        logic hold;   // timer frozen (self-refresh)
        logic clear;  // backlog dropped
        logic dec;    // one refresh issued
    } owed_ctl_t;

    function automatic int ns_to_cycles(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_interval_ctr.sv
module ref_interval_ctr
    import dram_ref_pkg::*;
#(
    parameter int INTERVAL_CYC = 1040,
    parameter int MAX_OWED     = 8,
    parameter int OWED_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  owed_ctl_t         ctl,
    output logic              tick,
    output logic [OWED_W-1:0] owed
);
    localparam int CNT_W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);
    localparam logic [OWED_W:0]  FULL = (OWED_W+1)'(MAX_OWED);

    logic [CNT_W-1:0] cnt;
    logic [OWED_W:0]  sum;

    always_ff @(posedge clk) begin
        if (rst || ctl.hold) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !ctl.hold && (cnt == LAST);

    always_comb begin
        sum = {1'b0, owed} + {{OWED_W{1'b0}}, tick};
        if (sum > FULL) begin
            sum = FULL;
        end
        if (ctl.dec && sum != '0) begin
            sum = sum - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            owed <= '0;
        end else begin
            owed <= sum[OWED_W-1:0];
        end
    end

    assert_owed_bound_R1: assert property (@(posedge clk) disable iff (rst)
        {1'b0, owed} <= FULL);

    assert_owed_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctl.dec && !ctl.clear && ({1'b0, owed} < FULL))
        |=> (owed == $past(owed) + 1'b1));

    assert_owed_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.dec && !tick && !ctl.clear && owed != '0)
        |=> (owed == $past(owed) - 1'b1));

endmodule

// File: rtl/ref_read_timer.sv
module ref_read_timer #(
    parameter int WAIT_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);
    localparam int W = $clog2(WAIT_CYC + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(WAIT_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ready = (cnt == '0);

    assert_read_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> !ready);

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
    import dram_ref_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int MAX_OWED  = 8,
    parameter int OWED_W    = 4,
    parameter int TRP_CYC   = 3,
    parameter int TRFC_CYC  = 10,
    parameter int TXSA_CYC  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OWED_W-1:0]    owed,
    input  logic [NUM_BANKS-1:0] banks_open,
    input  logic                 bus_idle,
    input  logic                 grant,
    input  logic                 sr_enter_req,
    input  logic                 sr_exit_req,
    output logic                 req,
    output logic                 urgent,
    output ref_cmd_e             cmd,
    output logic                 cke,
    output logic                 busy,
    output owed_ctl_t            ctl,
    output logic                 load_rd
);
    localparam int TRP_E  = max_int(TRP_CYC, 2);
    localparam int TRFC_E = max_int(TRFC_CYC, 2);
    localparam int TXSA_E = max_int(TXSA_CYC, 1);
    localparam int WMAX   = max_int(max_int(TRP_E, TRFC_E), TXSA_E);
    localparam int W      = $clog2(WMAX + 1);

    ref_state_e state, nxt;
    logic [W-1:0] wcnt, wcnt_nxt;
    logic sr_pend, pend_nxt;
    logic ref_want, go_sr;

    assign urgent   = (owed == OWED_W'(MAX_OWED));
    assign ref_want = (owed != '0) && (urgent || bus_idle);
    assign req      = (state == ST_IDLE) && (ref_want || sr_enter_req);
    assign go_sr    = sr_enter_req && !urgent;

    always_comb begin
        nxt      = state;
        wcnt_nxt = wcnt;
        pend_nxt = sr_pend;
        unique case (state)
            ST_IDLE: begin
                if (req && grant) begin
                    pend_nxt = go_sr;
                    if (|banks_open) begin
                        nxt = ST_PREA;
                    end else begin
                        nxt = go_sr ? ST_SRE : ST_AREF;
                    end
                end
            end
            ST_PREA: begin
                nxt      = ST_WAIT_RP;
                wcnt_nxt = W'(TRP_E - 2);
            end
            ST_WAIT_RP: begin
                if (wcnt == '0) begin
                    nxt = sr_pend ? ST_SRE : ST_AREF;
                end else begin
                    wcnt_nxt = wcnt - 1'b1;
                end
            end
            ST_AREF: begin
                nxt      = ST_WAIT_RFC;
                wcnt_nxt = W'(TRFC_E - 2);
            end
            ST_WAIT_RFC: begin
                if (wcnt == '0) begin
                    nxt = ST_IDLE;
                end else begin
                    wcnt_nxt = wcnt - 1'b1;
                end
            end
            ST_SRE: begin
                nxt = ST_SELF;
            end
            ST_SELF: begin
                if (sr_exit_req) begin
                    nxt      = ST_XS_WAIT;
                    wcnt_nxt = W'(TXSA_E - 1);
                end
            end
            ST_XS_WAIT: begin
                if (wcnt == '0) begin
                    nxt = ST_IDLE;
                end else begin
                    wcnt_nxt = wcnt - 1'b1;
                end
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            sr_pend <= 1'b0;
        end else begin
            state   <= nxt;
            wcnt    <= wcnt_nxt;
            sr_pend <= pend_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_PREA: cmd = CMD_PREA;
            ST_AREF: cmd = CMD_AREF;
            ST_SRE:  cmd = CMD_SRE;
            default: cmd = CMD_NOP;
        endcase
    end

    assign cke       = !((state == ST_SRE) || (state == ST_SELF));
    assign busy      = (state != ST_IDLE);
    assign ctl.hold  = !cke;
    assign ctl.clear = (state == ST_SRE);
    assign ctl.dec   = (state == ST_AREF);
    assign load_rd   = (state == ST_SELF) && sr_exit_req;

    assert_grant_acts_R3: assert property (@(posedge clk) disable iff (rst)
        (req && grant) |=> (cmd != CMD_NOP));

    assert_prea_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PREA) |=> (cmd == CMD_NOP && busy));

    assert_aref_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_AREF) |=> (cmd == CMD_NOP && busy));

    assert_cke_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (cmd == CMD_SRE));

    assert_self_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!cke && cmd != CMD_SRE) |-> (cmd == CMD_NOP && busy && !req));

    assert_cke_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> busy);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 7500,
    parameter int INTERVAL_CYC  = 1040,
    parameter int MAX_OWED      = 8,
    parameter int NUM_BANKS     = 4,
    parameter int TRP_NS        = 20,
    parameter int TRFC_NS       = 75,
    parameter int TXSA_NS       = 75,
    parameter int TXSRD_CYC     = 200,
    parameter int OWED_W        = $clog2(MAX_OWED + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] banks_open,
    input  logic                 bus_idle,
    input  logic                 grant,
    input  logic                 sr_enter_req,
    input  logic                 sr_exit_req,
    output logic                 ref_req,
    output logic                 ref_urgent,
    output logic [2:0]           cmd,
    output logic                 cke,
    output logic                 cmd_block,
    output logic                 read_ok,
    output logic [OWED_W-1:0]    owed_count
);
    localparam int TRP_CYC  = ns_to_cycles(TRP_NS, CLK_PERIOD_PS);
    localparam int TRFC_CYC = ns_to_cycles(TRFC_NS, CLK_PERIOD_PS);
    localparam int TXSA_CYC = ns_to_cycles(TXSA_NS, CLK_PERIOD_PS);

    owed_ctl_t ctl;
    ref_cmd_e  cmd_e;
    logic      tick;
    logic      load_rd;
    logic      rd_ready;

    ref_interval_ctr #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .MAX_OWED     (MAX_OWED),
        .OWED_W       (OWED_W)
    ) u_interval (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .tick (tick),
        .owed (owed_count)
    );

    ref_seq_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .MAX_OWED  (MAX_OWED),
        .OWED_W    (OWED_W),
        .TRP_CYC   (TRP_CYC),
        .TRFC_CYC  (TRFC_CYC),
        .TXSA_CYC  (TXSA_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .owed         (owed_count),
        .banks_open   (banks_open),
        .bus_idle     (bus_idle),
        .grant        (grant),
        .sr_enter_req (sr_enter_req),
        .sr_exit_req  (sr_exit_req),
        .req          (ref_req),
        .urgent       (ref_urgent),
        .cmd          (cmd_e),
        .cke          (cke),
        .busy         (cmd_block),
        .ctl          (ctl),
        .load_rd      (load_rd)
    );

    ref_read_timer #(
        .WAIT_CYC (TXSRD_CYC)
    ) u_read_wait (
        .clk   (clk),
        .rst   (rst),
        .load  (load_rd),
        .ready (rd_ready)
    );

    assign cmd     = cmd_e;
    assign read_ok = rd_ready && cke;

    // a refresh command never leaves the block while the timer keeps the backlog empty
    assert_aref_has_debt_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_e == CMD_AREF) |-> (owed_count != '0));

    assert_read_after_exit_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> !read_ok);

    wire unused_tick = tick;

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;

    localparam int PER_PS = 4000;
    localparam int INT    = 40;
    localparam int MAXO   = 8;
    localparam int NB     = 4;
    localparam int TRP    = (20 * 1000 + PER_PS - 1) / PER_PS;  // 5
    localparam int TRFC   = (75 * 1000 + PER_PS - 1) / PER_PS;  // 19
    localparam int TXSA   = (75 * 1000 + PER_PS - 1) / PER_PS;  // 19
    localparam int TXSRD  = 200;
    localparam int OW     = $clog2(MAXO + 1);
    localparam int C_NOP = 0, C_PREA = 1, C_AREF = 2, C_SRE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] banks_open = '0;
    logic          bus_idle = 1'b0;
    logic          grant = 1'b0;
    logic          sr_enter_req = 1'b0;
    logic          sr_exit_req = 1'b0;
    logic          ref_req, ref_urgent, cke, cmd_block, read_ok;
    logic [2:0]    cmd;
    logic [OW-1:0] owed_count;

    int checks = 0;
    int errors = 0;
    int n = 0;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .CLK_PERIOD_PS (PER_PS),
        .INTERVAL_CYC  (INT),
        .MAX_OWED      (MAXO),
        .NUM_BANKS     (NB),
        .TXSRD_CYC     (TXSRD)
    ) u_dram_refresh_sched (
        .clk          (clk),
        .rst          (rst),
        .banks_open   (banks_open),
        .bus_idle     (bus_idle),
        .grant        (grant),
        .sr_enter_req (sr_enter_req),
        .sr_exit_req  (sr_exit_req),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .cmd          (cmd),
        .cke          (cke),
        .cmd_block    (cmd_block),
        .read_ok      (read_ok),
        .owed_count   (owed_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        banks_open = '0; bus_idle = 1'b0; grant = 1'b0;
        sr_enter_req = 1'b0; sr_exit_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s;
        // ---------- R9 reset values ----------
        do_reset();
        chk("R9 cmd", cmd, C_NOP);
        chk("R9 cke", cke, 1);
        chk("R9 req", ref_req, 0);
        chk("R9 urgent", ref_urgent, 0);
        chk("R9 block", cmd_block, 0);
        chk("R9 read_ok", read_ok, 1);
        chk("R9 owed", owed_count, 0);

        // ---------- R1 R2 backlog sweep, no grant, bus busy ----------
        for (int k = 1; k <= 10; k++) begin
            repeat (INT - 1) step();
            chk("R1 owed before tick", owed_count, (k - 1 > MAXO) ? MAXO : k - 1);
            step();
            chk("R1 owed after tick", owed_count, (k > MAXO) ? MAXO : k);
            chk("R2 urgent", ref_urgent, (k >= MAXO) ? 1 : 0);
            chk("R2 req busy bus", ref_req, (k >= MAXO) ? 1 : 0);
        end
        bus_idle = 1'b1;
        #1 chk("R2 req idle bus full", ref_req, 1);

        // ---------- R3 R5 R10 banks closed, grant held ----------
        do_reset();
        bus_idle = 1'b1;
        grant = 1'b1;
        for (int i = 1; i <= 3 * INT + TRFC + 2; i++) begin
            step();
            chk("R3 cmd", cmd, (n > INT && (n - 1) % INT == 0) ? C_AREF : C_NOP);
            chk("R5 R10 block", cmd_block, (n > INT && (n - 1) % INT < TRFC) ? 1 : 0);
            if (n == INT) chk("R2 req optional", ref_req, 1);
            if (n == INT + 2) chk("R3 owed drop", owed_count, 0);
        end

        // ---------- R4 banks open ----------
        do_reset();
        bus_idle = 1'b1;
        grant = 1'b1;
        banks_open = 4'b0100;
        for (int i = 1; i <= 3 * INT + TRP + TRFC + 2; i++) begin
            int r;
            int e;
            step();
            r = (n - 1) % INT;
            e = C_NOP;
            if (n > INT && r == 0) e = C_PREA;
            if (n > INT && r == TRP) e = C_AREF;
            chk("R4 cmd", cmd, e);
            chk("R4 R5 block", cmd_block, (n > INT && r < TRP + TRFC) ? 1 : 0);
        end

        // ---------- R2 urgent burst with busy bus ----------
        do_reset();
        grant = 1'b1;
        while (n < 8 * INT) begin
            step();
            if (n % INT == 0 && n < 8 * INT) chk("R2 no req while busy", ref_req, 0);
        end
        chk("R2 urgent full", ref_urgent, 1);
        chk("R2 req full", ref_req, 1);
        step();
        chk("R3 urgent refresh", cmd, C_AREF);
        step();
        chk("R3 owed seven", owed_count, MAXO - 1);
        repeat (TRFC - 1) step();
        chk("R5 idle after hold", cmd_block, 0);
        chk("R2 req low busy bus", ref_req, 0);
        bus_idle = 1'b1;
        #1 chk("R2 req on idle bus", ref_req, 1);
        step();
        chk("R5 back to back refresh", cmd, C_AREF);

        // ---------- R6 R7 R8 self-refresh, banks closed ----------
        do_reset();
        repeat (3 * INT) step();
        chk("R1 owed three", owed_count, 3);
        sr_enter_req = 1'b1;
        grant = 1'b1;
        #1 chk("R2 req for entry", ref_req, 1);
        step();
        chk("R6 entry cmd", cmd, C_SRE);
        chk("R6 cke low", cke, 0);
        step();
        chk("R6 owed cleared", owed_count, 0);
        for (int i = 0; i < 3 * INT; i++) begin
            step();
            if (cke != 0 || cmd != C_NOP || cmd_block != 1) chk("R7 quiet", 0, 1);
        end
        chk("R7 timer stopped", owed_count, 0);
        chk("R7 cke", cke, 0);
        s = n;
        sr_enter_req = 1'b0;
        grant = 1'b0;
        sr_exit_req = 1'b1;
        step();
        sr_exit_req = 1'b0;
        chk("R8 cke rise", cke, 1);
        chk("R8 read blocked", read_ok, 0);
        chk("R8 block at rise", cmd_block, 1);
        while (n < s + TXSA) step();
        chk("R8 block last", cmd_block, 1);
        step();
        chk("R8 block released", cmd_block, 0);
        while (n < s + INT) step();
        chk("R8 timer restart before", owed_count, 0);
        step();
        chk("R8 timer restart after", owed_count, 1);
        while (n < s + TXSRD) step();
        chk("R8 read still blocked", read_ok, 0);
        step();
        chk("R8 read allowed", read_ok, 1);

        // ---------- R6 self-refresh with a bank open ----------
        do_reset();
        banks_open = 4'b0001;
        sr_enter_req = 1'b1;
        grant = 1'b1;
        step();
        chk("R6 precharge first", cmd, C_PREA);
        while (n < TRP) step();
        chk("R6 cke high before", cke, 1);
        step();
        chk("R6 entry after trp", cmd, C_SRE);
        chk("R6 cke low after", cke, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule